// File: doc/BRIEF.md
# Dual-Bank Memory Strobe Sequencer

This block sits between a synchronous host and a memory part in which a flash bank and an SRAM bank share address lines, data lines, output enable and write enable. Each bank has its own active-low enable. The host presents a request with a bank select, a read/write flag, a byte-lane mask, an address and write data. The block latches the request and plays out one bus cycle on the active-low pins. It drives the shared data bus only for writes, and it captures read data at the end of the output-enable window.

The block never selects both banks. A request that names neither bank or both banks is refused with a one-cycle error pulse, and the pins do not move. The width of the read and write strobes is a parameter counted in clock cycles, so one setting can meet the slower bank's pulse minimum. After each strobe there is one release cycle, during which the bank stays selected and the strobes are inactive. A new request may be accepted in that cycle. When the new request targets the same bank, its access follows at once. When it targets the other bank, the block first inserts one cycle with both enables high.

Top module: `dual_bank_strobe`

## Requirements
- R1: During and after reset, with no request, both bank enables, output enable, write enable and both byte strobes are high, the data drive is off, and `reqReady` is high.
- R2: `reqBankSel` bit 0 selects SRAM and bit 1 selects flash; exactly one bit must be set. Any other value is refused: `reqError` is high for one cycle starting one clock after the request, no enable or strobe goes low, and `reqReady` stays high. The two bank enables are never low in the same cycle.
- R3: An accepted read holds the selected bank enable low, output enable low and write enable high for `PULSE_CYC` cycles, starting the cycle after acceptance. The following release cycle keeps the bank enable low with output enable high. During the release cycle `rdValid` is high and `rdData` holds `memDin` as sampled on the last strobe cycle.
- R4: An accepted write holds the selected bank enable low and write enable low for exactly `PULSE_CYC` cycles, with output enable high throughout, and presents the request data on `memDout`. The address on `memAddr` is the request address for the whole access.
- R5: `reqByteEn` bit 1 enables the upper lane (data bits 15..8) and bit 0 enables the lower lane (bits 7..0). On SRAM accesses `memUpperN` and `memLowerN` go low, for each enabled lane, through the strobe and release cycles. On flash accesses both stay high.
- R6: `memDriveEn` is high only on writes, from the first strobe cycle through the release cycle, and never while output enable is low.
- R7: A request accepted in the release cycle that targets the other bank is preceded by exactly one cycle with both bank enables high.
- R8: A request accepted in the release cycle that targets the same bank keeps that bank enable low without a break.
- R9: While a strobe or gap cycle is under way, `reqReady` is low and a presented request has no effect: no extra access follows.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBankSel | input | 2 | Bit 0 SRAM, bit 1 flash; must be one-hot |
| reqByteEn | input | 2 | Lane enables, bit 1 upper, bit 0 lower |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | A request is accepted this cycle if valid |
| reqError | output | 1 | One-cycle pulse for a refused request |
| memDin | input | DATA_W | Data returned by the memory |
| memAddr | output | ADDR_W | Shared address lines |
| memDout | output | DATA_W | Data driven to the memory |
| memDriveEn | output | 1 | Data-bus drive control, high = drive |
| memSramEnN | output | 1 | SRAM bank enable, active low |
| memFlashEnN | output | 1 | Flash bank enable, active low |
| memOutEnN | output | 1 | Output enable, active low |
| memWrEnN | output | 1 | Write enable, active low |
| memUpperN | output | 1 | Upper byte strobe, active low |
| memLowerN | output | 1 | Lower byte strobe, active low |
| rdData | output | DATA_W | Captured read data |
| rdValid | output | 1 | `rdData` valid for one cycle |

## Verification
The pins are decoded directly from the phase register and the latched request. A wrong phase therefore shows up in the same cycle, either as a bank enable low outside an access or as a strobe whose width differs from `PULSE_CYC`. A stale bank bit appears as the wrong enable, or as a missing gap, on the first cycle of the next access. A wrong lane mask shows on the byte strobes during that same access. A capture in the wrong cycle is seen as a wrong `rdData` in the single `rdValid` cycle, because the bench changes `memDin` after the strobe window.

// File: rtl/dual_bank_strobe_pkg.sv
package dual_bank_strobe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_GAP     = 2'd1,
    PH_ACCESS  = 2'd2,
    PH_RELEASE = 2'd3
  } phase_t;

  typedef struct packed {
    logic bankOn;   // selected bank enable active
    logic oeOn;     // output enable active
    logic weOn;     // write enable active
    logic driveOn;  // drive data bus
    logic capture;  // sample read data this cycle
    logic load;     // latch a new request
  } strobe_t;

endpackage

// File: rtl/dual_bank_strobe_ctrl.sv
module dual_bank_strobe_ctrl
  import dual_bank_strobe_pkg::*;
#(
  parameter int PULSE_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqBankSel,
  input  logic       curFlash,
  input  logic       curWrite,
  output logic       reqReady,
  output logic       reqError,
  output strobe_t    strobe
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PULSE_CYC);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             selOk;
  logic             accept;
  logic             reject;
  logic             errReg;

  assign reqReady = (phase == PH_IDLE) || (phase == PH_RELEASE);
  assign selOk    = reqBankSel[0] ^ reqBankSel[1];
  assign accept   = reqValid && reqReady && selOk;
  assign reject   = reqValid && reqReady && !selOk;
  assign reqError = errReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      errReg <= 1'b0;
    end else begin
      errReg <= reject;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase <= PH_ACCESS;
            cnt   <= CNT_LOAD;
          end
        end
        PH_GAP: phase <= PH_ACCESS;
        PH_ACCESS: begin
          if (cnt == '0) phase <= PH_RELEASE;
          else           cnt   <= cnt - 1'b1;
        end
        PH_RELEASE: begin
          if (accept) begin
            phase <= (reqBankSel[1] != curFlash) ? PH_GAP : PH_ACCESS;
            cnt   <= CNT_LOAD;
          end else begin
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.bankOn  = (phase == PH_ACCESS) || (phase == PH_RELEASE);
    strobe.oeOn    = (phase == PH_ACCESS) && !curWrite;
    strobe.weOn    = (phase == PH_ACCESS) && curWrite;
    strobe.driveOn = strobe.bankOn && curWrite;
    strobe.capture = (phase == PH_ACCESS) && !curWrite && (cnt == '0);
    strobe.load    = accept;
  end

  // Checker state: length of the current write-enable pulse.
  logic [CNT_W-1:0] weCnt;
  always_ff @(posedge clk) begin
    if (!rstN)            weCnt <= '0;
    else if (strobe.weOn) weCnt <= (weCnt == CNT_FULL) ? weCnt : weCnt + 1'b1;
    else                  weCnt <= '0;
  end

  // R4: each write pulse lasts exactly PULSE_CYC cycles
  p_we_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.weOn && $past(strobe.weOn)) |-> (weCnt == CNT_FULL));

  // R2: a refused request leaves the bank idle
  p_error_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqError |-> (!strobe.bankOn && reqReady));

  // R9: no new access begins while the strobe or gap is under way
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACCESS && cnt != '0) |=> (phase == PH_ACCESS));

endmodule

// File: rtl/dual_bank_strobe_dp.sv
module dual_bank_strobe_dp
  import dual_bank_strobe_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              newFlash,
  input  logic              newWrite,
  input  logic [1:0]        newByteEn,
  input  logic [ADDR_W-1:0] newAddr,
  input  logic [DATA_W-1:0] newWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic              curFlash,
  output logic              curWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDriveEn,
  output logic              memSramEnN,
  output logic              memFlashEnN,
  output logic              memOutEnN,
  output logic              memWrEnN,
  output logic              memUpperN,
  output logic              memLowerN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int LANES = 2;

  logic [LANES-1:0]  latByteEn;
  logic [ADDR_W-1:0] latAddr;
  logic [DATA_W-1:0] latWdata;
  logic [LANES-1:0]  laneN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curFlash  <= 1'b0;
      curWrite  <= 1'b0;
      latByteEn <= '0;
      latAddr   <= '0;
      latWdata  <= '0;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      if (strobe.load) begin
        curFlash  <= newFlash;
        curWrite  <= newWrite;
        latByteEn <= newByteEn;
        latAddr   <= newAddr;
        latWdata  <= newWdata;
      end
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= memDin;
    end
  end

  // One strobe per byte lane; lanes act only on the SRAM bank.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneN[g] = ~(strobe.bankOn & ~curFlash & latByteEn[g]);
  end

  assign memLowerN   = laneN[0];
  assign memUpperN   = laneN[1];
  assign memSramEnN  = ~(strobe.bankOn & ~curFlash);
  assign memFlashEnN = ~(strobe.bankOn & curFlash);
  assign memOutEnN   = ~strobe.oeOn;
  assign memWrEnN    = ~strobe.weOn;
  assign memDriveEn  = strobe.driveOn;
  assign memAddr     = latAddr;
  assign memDout     = latWdata;

  // R2: bank enables exclusive
  p_bank_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(!memSramEnN && !memFlashEnN));

  // R7: entering one bank requires the other to have been idle last cycle
  p_switch_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!memFlashEnN |-> $past(memSramEnN)) and (!memSramEnN |-> $past(memFlashEnN)));

  // R3: output enable never with write enable
  p_read_we_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memOutEnN |-> memWrEnN);

  // R6: no bus drive while outputs are enabled
  p_drive_oe_r6: assert property (@(posedge clk) disable iff (!rstN)
    memDriveEn |-> memOutEnN);

  // R5: byte strobes stay high on flash accesses
  p_lane_flash_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memFlashEnN |-> (memUpperN && memLowerN));

endmodule

// File: rtl/dual_bank_strobe.sv
module dual_bank_strobe
  import dual_bank_strobe_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int PULSE_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqBankSel,
  input  logic [1:0]        reqByteEn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              reqError,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDriveEn,
  output logic              memSramEnN,
  output logic              memFlashEnN,
  output logic              memOutEnN,
  output logic              memWrEnN,
  output logic              memUpperN,
  output logic              memLowerN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  strobe_t strobe;
  logic    curFlash;
  logic    curWrite;

  dual_bank_strobe_ctrl #(.PULSE_CYC(PULSE_CYC)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqBankSel (reqBankSel),
    .curFlash   (curFlash),
    .curWrite   (curWrite),
    .reqReady   (reqReady),
    .reqError   (reqError),
    .strobe     (strobe)
  );

  dual_bank_strobe_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .newFlash    (reqBankSel[1]),
    .newWrite    (reqWrite),
    .newByteEn   (reqByteEn),
    .newAddr     (reqAddr),
    .newWdata    (reqWdata),
    .memDin      (memDin),
    .curFlash    (curFlash),
    .curWrite    (curWrite),
    .memAddr     (memAddr),
    .memDout     (memDout),
    .memDriveEn  (memDriveEn),
    .memSramEnN  (memSramEnN),
    .memFlashEnN (memFlashEnN),
    .memOutEnN   (memOutEnN),
    .memWrEnN    (memWrEnN),
    .memUpperN   (memUpperN),
    .memLowerN   (memLowerN),
    .rdData      (rdData),
    .rdValid     (rdValid)
  );

endmodule

// File: tb/dual_bank_strobe_test.sv
module dual_bank_strobe_test;

  localparam int AW = 18;
  localparam int DW = 16;
  localparam int P  = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [1:0]    reqBankSel = 2'b00;
  logic [1:0]    reqByteEn = 2'b00;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [DW-1:0] memDin = '0;
  logic          reqReady, reqError, memDriveEn, rdValid;
  logic          memSramEnN, memFlashEnN, memOutEnN, memWrEnN, memUpperN, memLowerN;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDout, rdData;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_bank_strobe #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(P)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBankSel(reqBankSel), .reqByteEn(reqByteEn), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqReady(reqReady), .reqError(reqError),
    .memDin(memDin), .memAddr(memAddr), .memDout(memDout),
    .memDriveEn(memDriveEn), .memSramEnN(memSramEnN), .memFlashEnN(memFlashEnN),
    .memOutEnN(memOutEnN), .memWrEnN(memWrEnN), .memUpperN(memUpperN),
    .memLowerN(memLowerN), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(string req);
    chk(req, "sramEnN", memSramEnN, 1);
    chk(req, "flashEnN", memFlashEnN, 1);
    chk(req, "oeN", memOutEnN, 1);
    chk(req, "weN", memWrEnN, 1);
    chk(req, "upperN", memUpperN, 1);
    chk(req, "lowerN", memLowerN, 1);
    chk(req, "drive", memDriveEn, 0);
  endtask

  // Called at a negedge; presents a request for one edge, returns at the next negedge.
  task automatic issue(logic [1:0] sel, logic wr, logic [1:0] be, logic [AW-1:0] a, logic [DW-1:0] d);
    reqBankSel = sel; reqWrite = wr; reqByteEn = be; reqAddr = a; reqWdata = d;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Starts at first strobe cycle, ends at the release cycle (both at a negedge).
  task automatic checkAccess(string req, logic flash, logic wr, logic [1:0] be,
                             logic [AW-1:0] a, logic [DW-1:0] d);
    for (int i = 0; i < P; i++) begin
      chk(req, "sramEnN", memSramEnN, flash);
      chk(req, "flashEnN", memFlashEnN, !flash);
      chk(req, "oeN", memOutEnN, wr);
      chk(req, "weN", memWrEnN, !wr);
      chk(req, "drive", memDriveEn, wr);
      chk(req, "upperN", memUpperN, !(!flash && be[1]));
      chk(req, "lowerN", memLowerN, !(!flash && be[0]));
      chk(req, "addr", memAddr, a);
      chk(req, "ready", reqReady, 0);
      if (wr) chk(req, "dout", memDout, d);
      @(negedge clk);
    end
    chk(req, "rel sramEnN", memSramEnN, flash);
    chk(req, "rel flashEnN", memFlashEnN, !flash);
    chk(req, "rel oeN", memOutEnN, 1);
    chk(req, "rel weN", memWrEnN, 1);
    chk(req, "rel drive", memDriveEn, wr);
    chk(req, "rel upperN", memUpperN, !(!flash && be[1]));
    chk(req, "rel ready", reqReady, 1);
    chk(req, "rel rdValid", rdValid, !wr);
  endtask

  task automatic testReset();
    checkIdle("R1");
    chk("R1", "ready", reqReady, 1);
    chk("R1", "error", reqError, 0);
    chk("R1", "rdValid", rdValid, 0);
  endtask

  task automatic testSramRead();
    memDin = 16'hA5C3;
    issue(2'b01, 1'b0, 2'b11, 18'h01234, 16'h0);
    // memDin changes after the capture edge; rdData must keep the sampled value
    fork
      begin repeat (P) @(posedge clk); #2 memDin = 16'h1111; end
    join_none
    checkAccess("R3", 1'b0, 1'b0, 2'b11, 18'h01234, 16'h0);
    chk("R3", "rdData", rdData, 16'hA5C3);
    @(negedge clk);
    checkIdle("R1");
    chk("R3", "rdValid after", rdValid, 0);
  endtask

  task automatic testSramWriteUpper();
    issue(2'b01, 1'b1, 2'b10, 18'h00F0F, 16'hBEEF);
    checkAccess("R5", 1'b0, 1'b1, 2'b10, 18'h00F0F, 16'hBEEF);
    @(negedge clk);
    checkIdle("R6");
  endtask

  task automatic testFlashWrite();
    issue(2'b10, 1'b1, 2'b11, 18'h2AAAA, 16'h00A0);
    checkAccess("R4", 1'b1, 1'b1, 2'b11, 18'h2AAAA, 16'h00A0);
    @(negedge clk);
    checkIdle("R4");
  endtask

  task automatic testBankSwitch();
    memDin = 16'h5A5A;
    issue(2'b10, 1'b0, 2'b01, 18'h15555, 16'h0);
    checkAccess("R3", 1'b1, 1'b0, 2'b01, 18'h15555, 16'h0);
    chk("R3", "flash rdData", rdData, 16'h5A5A);
    issue(2'b01, 1'b0, 2'b01, 18'h00007, 16'h0);
    chk("R7", "gap sramEnN", memSramEnN, 1);
    chk("R7", "gap flashEnN", memFlashEnN, 1);
    chk("R7", "gap ready", reqReady, 0);
    @(negedge clk);
    checkAccess("R7", 1'b0, 1'b0, 2'b01, 18'h00007, 16'h0);
    @(negedge clk);
    checkIdle("R7");
  endtask

  task automatic testSameBank();
    issue(2'b01, 1'b1, 2'b01, 18'h00100, 16'h1234);
    checkAccess("R8", 1'b0, 1'b1, 2'b01, 18'h00100, 16'h1234);
    issue(2'b01, 1'b1, 2'b11, 18'h00101, 16'h5678);
    checkAccess("R8", 1'b0, 1'b1, 2'b11, 18'h00101, 16'h5678);
    @(negedge clk);
    checkIdle("R8");
  endtask

  task automatic testRefuse();
    issue(2'b11, 1'b1, 2'b11, 18'h00200, 16'hFFFF);
    chk("R2", "error both", reqError, 1);
    chk("R2", "ready both", reqReady, 1);
    checkIdle("R2");
    @(negedge clk);
    chk("R2", "error pulse", reqError, 0);
    checkIdle("R2");
    issue(2'b00, 1'b0, 2'b11, 18'h00200, 16'h0);
    chk("R2", "error none", reqError, 1);
    checkIdle("R2");
    @(negedge clk);
    checkIdle("R2");
  endtask

  task automatic testBusy();
    issue(2'b01, 1'b0, 2'b11, 18'h00300, 16'h0);
    chk("R9", "busy ready", reqReady, 0);
    reqBankSel = 2'b10; reqWrite = 1'b1; reqAddr = 18'h00333; reqValid = 1'b1;
    @(negedge clk);
    chk("R9", "addr held", memAddr, 18'h00300);
    chk("R9", "flash idle", memFlashEnN, 1);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9", "still read", memWrEnN, 1);
    @(negedge clk);
    chk("R9", "release", memSramEnN, 0);
    @(negedge clk);
    checkIdle("R9");
    chk("R9", "addr final", memAddr, 18'h00300);
    @(negedge clk);
    checkIdle("R9");
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSramRead();
    testSramWriteUpper();
    testFlashWrite();
    testBankSwitch();
    testSameBank();
    testRefuse();
    testBusy();
    done = 1'b1;
    finishRun();
  end

endmodule